// File: doc/BRIEF.md
# Multi-Event Storage Block Manager

This block keeps account of a bank of 32 analog storage blocks, each 32 cells deep, that together make a 1024-cell multi-event buffer. A sampling controller hands over a full sampling bank (A or B, used in ping-pong) through a valid/ready transfer request. The manager gives that transfer the next free storage block in strict arrival order. It then drives a write phase of fixed length, in which the write-enable is tagged with the bank and the block address does not change. An event longer than one block needs no length setting. Triggers spaced one block apart simply fill consecutive blocks.

On the drain side, two independent single-cycle commands act on the oldest stored block. The read command raises a start-conversion pulse for the block at the read address. The move command releases that block and steps the read address to the next one. Move after read means the block was digitised. Move alone discards it. An occupancy flag for each block feeds the full and empty indicators.

Transfer handshake rules: a request is taken on a clock edge where `xfer_valid` and `xfer_ready` are both high. `xfer_ready` is high only when three things hold: the sequencer is waiting, the offered `xfer_bank` is the bank it expects, and the buffer is not full. A request that is not taken must be held until it is taken. Commands, conversion signals and flags are plain level or pulse signals.

Top module: `evt_store_mgr`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `wr_addr`=0, `rd_addr`=0, `wr_en`=0 and `conv_start`=0, and the sequencer expects bank A (`xfer_bank`=0).
- R2: Accepted transfers alternate A, B, A, B. While the sequencer expects one bank, `xfer_ready` is low for a request that names the other bank.
- R3: The cycle after a handshake, `wr_en` goes high and stays high for exactly WR_CYC cycles (4 by default). During this time `wr_bank` equals the accepted bank (0=A, 1=B) and `wr_addr` stays constant.
- R4: Successive transfers get consecutive block addresses. `wr_addr` advances by one when a write phase ends and wraps from 31 to 0.
- R5: `full` is high exactly when all 32 blocks hold data. While `full` is high, `xfer_ready` stays low.
- R6: A read command accepted on an edge gives `conv_start` high for exactly the next cycle, and `rd_addr` does not change.
- R7: From the accepted read until `conv_done` arrives, a conversion is pending. During that time further read and move commands are ignored, so there is no `conv_start` and no address change.
- R8: An accepted move clears the occupancy of the block at `rd_addr` and advances `rd_addr` by one, modulo 32. A move without a read discards the block.
- R9: While `empty` is high, read and move commands are ignored.
- R10: When read and move come in the same cycle and the read is accepted, the read takes effect and the move is ignored.
- R11: A write phase that ends in the same cycle as an accepted move on a different block both sets the written block and clears the moved one.
- R12: `empty` is high exactly when no block holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | Transfer request from the sampling controller |
| xfer_bank | input | 1 | Bank of the request, 0=A, 1=B |
| xfer_ready | output | 1 | Request can be taken this cycle |
| wr_en | output | 1 | Write phase active |
| wr_bank | output | 1 | Bank being written, 0=A, 1=B |
| wr_addr | output | 5 | Storage block being written / next to write |
| rd_cmd | input | 1 | Read command pulse |
| mv_cmd | input | 1 | Move command pulse |
| conv_done | input | 1 | Conversion finished |
| rd_addr | output | 5 | Oldest stored block |
| conv_start | output | 1 | Start-conversion pulse |
| full | output | 1 | All blocks occupied |
| empty | output | 1 | No block occupied |

## Verification
Two functions can hit the occupancy map in the same cycle: the end of a write phase sets one block, and a move clears another. The bench provokes this after the buffer has filled. It releases one block, starts a new transfer, and issues a move on the last write cycle. It then judges the outcome at the ports. `full` must drop, which shows the clear happened. Exactly 31 further moves must be needed before `empty` rises, which shows the set also happened.

// File: rtl/evt_store_pkg.sv
`timescale 1ns/1ps
package evt_store_pkg;
  typedef enum logic [1:0] {
    WS_WAIT_A = 2'd0,
    WS_LOAD_A = 2'd1,
    WS_WAIT_B = 2'd2,
    WS_LOAD_B = 2'd3
  } wseq_t;

  localparam logic BANK_A = 1'b0;
  localparam logic BANK_B = 1'b1;
endpackage

// File: rtl/esm_wr_seq.sv
`timescale 1ns/1ps
module esm_wr_seq
  import evt_store_pkg::*;
#(
  parameter int NUM_BLK = 32,
  parameter int WR_CYC  = 4,
  localparam int AW     = $clog2(NUM_BLK),
  localparam int CW     = (WR_CYC > 1) ? $clog2(WR_CYC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_valid,
  input  logic          xfer_bank,
  input  logic          full,
  output logic          xfer_ready,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_ptr,
  output logic          set_en
);
  wseq_t         state;
  logic [CW-1:0] cnt;
  logic          last;
  logic          take;

  assign last = (cnt == CW'(WR_CYC - 1));
  assign xfer_ready = !full &&
                      (((state == WS_WAIT_A) && (xfer_bank == BANK_A)) ||
                       ((state == WS_WAIT_B) && (xfer_bank == BANK_B)));
  assign take    = xfer_valid && xfer_ready;
  assign wr_en   = (state == WS_LOAD_A) || (state == WS_LOAD_B);
  assign wr_bank = (state == WS_LOAD_B);
  assign set_en  = wr_en && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= WS_WAIT_A;
      cnt    <= '0;
      wr_ptr <= '0;
    end else begin
      unique case (state)
        WS_WAIT_A: if (take) begin state <= WS_LOAD_A; cnt <= '0; end
        WS_WAIT_B: if (take) begin state <= WS_LOAD_B; cnt <= '0; end
        WS_LOAD_A, WS_LOAD_B: begin
          if (last) begin
            state  <= (state == WS_LOAD_A) ? WS_WAIT_B : WS_WAIT_A;
            wr_ptr <= wr_ptr + 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= WS_WAIT_A;
      endcase
    end
  end

  // R2: after bank A is written the sequencer waits for bank B
  a_r2_a_then_b: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_LOAD_A && last) |=> (state == WS_WAIT_B));
  // R3: block address held while the write phase continues
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !last) |=> (wr_en && $stable(wr_ptr)));
  // R4: one step per completed write
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));
endmodule

// File: rtl/esm_rd_ctrl.sv
`timescale 1ns/1ps
module esm_rd_ctrl #(
  parameter int NUM_BLK = 32,
  localparam int AW     = $clog2(NUM_BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_cmd,
  input  logic          mv_cmd,
  input  logic          conv_done,
  input  logic          empty,
  output logic [AW-1:0] rd_ptr,
  output logic          conv_start,
  output logic          clr_en
);
  logic busy;
  logic do_read;

  assign do_read = rd_cmd && !empty && !busy;
  assign clr_en  = mv_cmd && !rd_cmd && !empty && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= do_read;
      if (do_read) busy <= 1'b1;
      else if (busy && conv_done) busy <= 1'b0;
      if (clr_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R6: a start pulse never lasts two cycles
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R7: pending conversion blocks a new start
  a_r7_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_start);
  // R8: accepted move advances the read address by one
  a_r8_move_step: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1)));
  // R9: nothing moves while the buffer is empty
  a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> ($stable(rd_ptr) && !conv_start));
endmodule

// File: rtl/esm_occ_map.sv
`timescale 1ns/1ps
module esm_occ_map #(
  parameter int NUM_BLK = 32,
  localparam int AW     = $clog2(NUM_BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx,
  output logic          full,
  output logic          empty
);
  logic [NUM_BLK-1:0] flags;

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else if (set_en && (set_idx == AW'(i))) flags[i] <= 1'b1;
      else if (clr_en && (clr_idx == AW'(i))) flags[i] <= 1'b0;
    end
  end

  assign full  = &flags;
  assign empty = ~|flags;

  // R11: simultaneous set and clear of different blocks both land
  a_r11_set_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && clr_en && (set_idx != clr_idx)) |=>
      (flags[$past(set_idx)] && !flags[$past(clr_idx)]));
  // R5: a set alone can only increase occupancy
  a_r5_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> !empty);
endmodule

// File: rtl/evt_store_mgr.sv
`timescale 1ns/1ps
module evt_store_mgr #(
  parameter int NUM_BLK = 32,
  parameter int WR_CYC  = 4,
  localparam int AW     = $clog2(NUM_BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_valid,
  input  logic          xfer_bank,
  output logic          xfer_ready,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  input  logic          rd_cmd,
  input  logic          mv_cmd,
  input  logic          conv_done,
  output logic [AW-1:0] rd_addr,
  output logic          conv_start,
  output logic          full,
  output logic          empty
);
  logic set_en;
  logic clr_en;

  esm_wr_seq #(.NUM_BLK(NUM_BLK), .WR_CYC(WR_CYC)) u_wr (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_bank(xfer_bank),
    .full(full), .xfer_ready(xfer_ready), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_ptr(wr_addr), .set_en(set_en)
  );

  esm_rd_ctrl #(.NUM_BLK(NUM_BLK)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .mv_cmd(mv_cmd),
    .conv_done(conv_done), .empty(empty), .rd_ptr(rd_addr),
    .conv_start(conv_start), .clr_en(clr_en)
  );

  esm_occ_map #(.NUM_BLK(NUM_BLK)) u_occ (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_idx(wr_addr),
    .clr_en(clr_en), .clr_idx(rd_addr), .full(full), .empty(empty)
  );

  // R5: a full buffer never accepts a transfer
  a_r5_no_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && xfer_valid) |-> !xfer_ready);
  // R12: empty and full never together
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: tb/evt_store_mgr_test.sv
`timescale 1ns/1ps
module evt_store_mgr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_valid = 1'b0, xfer_bank = 1'b0;
  logic       rd_cmd = 1'b0, mv_cmd = 1'b0, conv_done = 1'b0;
  logic       xfer_ready, wr_en, wr_bank, conv_start, full, empty;
  logic [4:0] wr_addr, rd_addr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic       exp_bank = 1'b0;
  logic [4:0] exp_wa = 5'd0;

  always #2 clk = ~clk;

  evt_store_mgr uut (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_bank(xfer_bank),
    .xfer_ready(xfer_ready), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .rd_cmd(rd_cmd), .mv_cmd(mv_cmd), .conv_done(conv_done), .rd_addr(rd_addr),
    .conv_start(conv_start), .full(full), .empty(empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input bit mv_last);
    @(negedge clk); xfer_valid = 1'b1; xfer_bank = exp_bank;
    #1 chk("R2 ready for expected bank", int'(xfer_ready), 1);
    @(negedge clk); xfer_valid = 1'b0;
    #1 chk("R3 wr_en high", int'(wr_en), 1);
    chk("R3 wr_bank", int'(wr_bank), int'(exp_bank));
    chk("R4 wr_addr during write", int'(wr_addr), int'(exp_wa));
    repeat (2) @(negedge clk);
    #1 chk("R3 wr_en still high", int'(wr_en), 1);
    @(negedge clk); if (mv_last) mv_cmd = 1'b1;
    @(negedge clk); mv_cmd = 1'b0;
    #1 chk("R3 wr_en low after WR_CYC", int'(wr_en), 0);
    exp_wa   = exp_wa + 5'd1;
    exp_bank = ~exp_bank;
    chk("R4 wr_addr advanced", int'(wr_addr), int'(exp_wa));
  endtask

  task automatic do_read(input bit with_move, input bit expect_start);
    @(negedge clk); rd_cmd = 1'b1; mv_cmd = with_move;
    @(negedge clk); rd_cmd = 1'b0; mv_cmd = 1'b0;
    #1 chk("R6 conv_start pulse", int'(conv_start), int'(expect_start));
    @(negedge clk);
    #1 chk("R6 conv_start one cycle", int'(conv_start), 0);
    if (expect_start) begin
      rd_cmd = 1'b1; mv_cmd = 1'b0;
      @(negedge clk); rd_cmd = 1'b0;
      #1 chk("R7 read ignored while pending", int'(conv_start), 0);
      mv_cmd = 1'b1;
      @(negedge clk); mv_cmd = 1'b0;
      conv_done = 1'b1;
      @(negedge clk); conv_done = 1'b0;
    end
  endtask

  task automatic do_move();
    @(negedge clk); mv_cmd = 1'b1;
    @(negedge clk); mv_cmd = 1'b0;
  endtask

  // op: 0 write, 1 read, 2 move, 3 read and move together
  typedef struct packed {
    logic [1:0] op;
    logic [4:0] wa;
    logic [4:0] ra;
    logic       emp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd0, 5'd1, 5'd0, 1'b0},   // R4 first block
    '{2'd0, 5'd2, 5'd0, 1'b0},   // R2 bank B
    '{2'd1, 5'd2, 5'd0, 1'b0},   // R6 read keeps address; R7 move while pending
    '{2'd2, 5'd2, 5'd1, 1'b0},   // R8 move after read
    '{2'd2, 5'd2, 5'd2, 1'b1},   // R8 discard; R12 empty
    '{2'd2, 5'd2, 5'd2, 1'b1},   // R9 move on empty ignored
    '{2'd0, 5'd3, 5'd2, 1'b0},   // R4 third block
    '{2'd3, 5'd3, 5'd2, 1'b0},   // R10 read wins over move
    '{2'd2, 5'd3, 5'd3, 1'b1}    // R8 drain
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1 chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 wr_addr", int'(wr_addr), 0);
    chk("R1 rd_addr", int'(rd_addr), 0);
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 conv_start", int'(conv_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    xfer_bank = 1'b1;
    #1 chk("R1 bank B not expected", int'(xfer_ready), 0);
    xfer_bank = 1'b0;
    #1 chk("R1 bank A expected", int'(xfer_ready), 1);

    for (int i = 0; i < 9; i++) begin
      case (VEC[i].op)
        2'd0: do_write(1'b0);
        2'd1: do_read(1'b0, 1'b1);
        2'd2: do_move();
        default: do_read(1'b1, 1'b1);
      endcase
      #1;
      chk("R4 table wr_addr", int'(wr_addr), int'(VEC[i].wa));
      chk("R8 table rd_addr", int'(rd_addr), int'(VEC[i].ra));
      chk("R12 table empty", int'(empty), int'(VEC[i].emp));
      chk("R5 table full", int'(full), 0);
    end

    // R9: read on empty buffer gives no conversion
    do_read(1'b0, 1'b0);
    chk("R9 rd_addr unchanged", int'(rd_addr), 3);

    // R2: waiting for B, bank A refused
    @(negedge clk); xfer_valid = 1'b1; xfer_bank = 1'b0;
    #1 chk("R2 wrong bank refused", int'(xfer_ready), 0);
    @(negedge clk); xfer_valid = 1'b0;

    // R5: fill all 32 blocks, wrap of write address (R4)
    for (int i = 0; i < 32; i++) begin
      #1 chk("R5 not full before last", int'(full), 0);
      do_write(1'b0);
    end
    #1 chk("R5 full after 32", int'(full), 1);
    chk("R4 wr_addr wrapped", int'(wr_addr), 3);
    @(negedge clk); xfer_valid = 1'b1; xfer_bank = exp_bank;
    #1 chk("R5 ready low when full", int'(xfer_ready), 0);
    @(negedge clk); xfer_valid = 1'b0;
    #1 chk("R5 no write when full", int'(wr_en), 0);

    // R11: free one block, then write it while a move clears the next
    do_move();
    #1 chk("R5 full drops after move", int'(full), 0);
    do_write(1'b1);
    #1 chk("R11 clear took effect", int'(full), 0);
    chk("R11 rd_addr", int'(rd_addr), 5);
    for (int i = 0; i < 30; i++) do_move();
    #1 chk("R11 set took effect (not empty after 30)", int'(empty), 0);
    do_move();
    #1 chk("R12 empty after 31 moves", int'(empty), 1);
    chk("R8 rd_addr wrapped", int'(rd_addr), 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule